// File: doc/BRIEF.md
# Eight-Port Packet Interleaving Multiplexer

This block merges packet streams from several ingress ports onto one shared 134-bit datapath. Each port has a private 16-entry queue that its writer fills one word per cycle. A round-robin grant picks one non-empty queue and drains it onto the output. The grant moves on when a packet finishes or when 128 bytes (eight 16-byte words) of the current grant have gone out. Long packets from different ports therefore leave interleaved in 128-byte slices.

Every output word carries the number of the port it came from, so a later stage can rebuild each packet from its slices. Each writer sees a private not-ready flag that rises while its queue has only two free slots left. This gives a writer that reacts one cycle late enough room to stop. The output follows a valid/ready handshake.

Top module: `pkt_ilv_mux`

## Requirements
- R1: A word is 134 bits: bit 133 is start-of-packet, bit 132 is end-of-packet, bits 131:128 are the valid-byte count of a final word (0 meaning all 16), and bits 127:0 are payload. Words leave exactly as they were written.
- R2: Each port owns a 16-entry queue, and words of one port leave in the order they were written.
- R3: `in_stall[p]` is high exactly when port p's queue holds 14 or more words (2 or fewer free), starting from the clock edge that stores or removes the word that changes the count.
- R4: `out_port` gives the index of the port whose queue supplied `out_word`.
- R5: A new grant goes to the first non-empty port after the last granted port, in increasing order with wrap-around, and empty ports are skipped. After reset the search starts at port 0.
- R6: A grant ends when an end-of-packet word is accepted.
- R7: A grant ends after its 8th accepted word. The word count restarts at every grant, and an end-of-packet on the 8th word ends the grant only once.
- R8: While `out_valid` is high and `out_ready` is low, `out_word` and `out_port` hold steady. Every written word leaves exactly once.
- R9: `out_valid` is low after reset and whenever all queues are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 8 | Per-port write strobe |
| in_word | input | 8*134 | Per-port write words, port p at bits p*134 upward |
| in_stall | output | 8 | Per-port not-ready flag toward the writers |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_word | output | 134 | Output word |
| out_port | output | 3 | Source port of the output word |

## Verification
A write is stored at the next rising edge, and `in_stall` reflects the new count from that same edge. When the block is idle, the first word of a fresh grant appears two edges after its write: one edge stores the word and one takes the grant. After a word is accepted, the next word, or the bubble between grants, appears at that same edge. The bench drives all inputs at the falling edge and reads the outputs 1 ns later, as the values the coming rising edge will act on. It compares queue fill and handshakes against its own per-port occupancy model every cycle, so every check lands in the cycle the design is due to respond.

// File: rtl/pim_pkg.sv
package pim_pkg;

    localparam int PIM_PORTS       = 8;
    localparam int PIM_DEPTH       = 16;
    localparam int PIM_STALL_FREE  = 2;
    localparam int DATA_W          = 128;
    localparam int BE_W            = 4;
    localparam int CHUNK_BYTES     = 128;
    localparam int BYTES_PER_WORD  = DATA_W / 8;
    localparam int PIM_CHUNK_WORDS = CHUNK_BYTES / BYTES_PER_WORD;

    // one queue entry; field order fixes the bit positions seen downstream
    typedef struct packed {
        logic              sof;
        logic              eof;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] data;
    } pkt_word_t;

    localparam int PKT_W   = $bits(pkt_word_t);
    localparam int EOF_BIT = DATA_W + BE_W;
    localparam int SOF_BIT = EOF_BIT + 1;

endpackage

// File: rtl/port_fifo.sv
module port_fifo #(
    parameter int WIDTH      = 134,
    parameter int DEPTH      = 16,
    parameter int STALL_FREE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             stall
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    cnt_q;
    logic             do_wr, do_rd;

    assign do_wr   = wr_en && (cnt_q != CW'(DEPTH));
    assign do_rd   = rd_en && (cnt_q != '0);
    assign empty   = (cnt_q == '0);
    assign stall   = (cnt_q >= CW'(DEPTH - STALL_FREE));
    assign rd_data = mem[rd_ptr_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] ptr);
        return (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_wr) wr_ptr_q <= bump(wr_ptr_q);
            if (do_rd) rd_ptr_q <= bump(rd_ptr_q);
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 8,
    parameter int PW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] prev,
    output logic          found,
    output logic [PW-1:0] pick
);
    logic [PW:0] sum;
    logic [PW:0] idx;

    // walk from the farthest offset down so the nearest requester wins
    always_comb begin
        found = 1'b0;
        pick  = prev;
        sum   = '0;
        idx   = '0;
        for (int off = N; off >= 1; off--) begin
            sum = {1'b0, prev} + (PW + 1)'(off);
            idx = (sum >= (PW + 1)'(N)) ? sum - (PW + 1)'(N) : sum;
            if (req[idx[PW-1:0]]) begin
                found = 1'b1;
                pick  = idx[PW-1:0];
            end
        end
    end
endmodule

// File: rtl/grant_ctrl.sv
module grant_ctrl #(
    parameter int N     = 8,
    parameter int PW    = 3,
    parameter int CHUNK = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  nonempty,
    input  logic          head_eof,
    input  logic          out_ready,
    output logic          out_valid,
    output logic          fire,
    output logic [PW-1:0] cur
);
    localparam int BW = (CHUNK > 1) ? $clog2(CHUNK) : 1;

    logic          busy_q;
    logic [PW-1:0] cur_q;
    logic [BW-1:0] beat_q;
    logic          found;
    logic [PW-1:0] pick;
    logic          last_beat, release_now;

    rr_pick #(.N(N), .PW(PW)) u_pick (
        .req   (nonempty),
        .prev  (cur_q),
        .found (found),
        .pick  (pick)
    );

    assign out_valid   = busy_q && nonempty[cur_q];
    assign fire        = out_valid && out_ready;
    assign last_beat   = (beat_q == BW'(CHUNK - 1));
    assign release_now = fire && (head_eof || last_beat);
    assign cur         = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cur_q  <= PW'(N - 1);
            beat_q <= '0;
        end else if (!busy_q) begin
            if (found) begin
                busy_q <= 1'b1;
                cur_q  <= pick;
                beat_q <= '0;
            end
        end else if (fire) begin
            if (release_now) begin
                busy_q <= 1'b0;
                beat_q <= '0;
            end else begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pkt_ilv_mux.sv
module pkt_ilv_mux
    import pim_pkg::*;
#(
    parameter int NUM_PORTS   = PIM_PORTS,
    parameter int FIFO_DEPTH  = PIM_DEPTH,
    parameter int CHUNK_WORDS = PIM_CHUNK_WORDS,
    parameter int STALL_FREE  = PIM_STALL_FREE
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_PORTS-1:0]         in_valid,
    input  logic [NUM_PORTS*PKT_W-1:0]   in_word,
    output logic [NUM_PORTS-1:0]         in_stall,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [PKT_W-1:0]             out_word,
    output logic [$clog2(NUM_PORTS)-1:0] out_port
);
    localparam int PORT_W = $clog2(NUM_PORTS);

    logic [NUM_PORTS-1:0] fifo_empty;
    logic [NUM_PORTS-1:0] rd_en;
    logic [PKT_W-1:0]     head [NUM_PORTS];
    logic [PORT_W-1:0]    cur;
    logic                 fire;
    logic                 head_eof;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign rd_en[p] = fire && (cur == PORT_W'(p));

        port_fifo #(
            .WIDTH      (PKT_W),
            .DEPTH      (FIFO_DEPTH),
            .STALL_FREE (STALL_FREE)
        ) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (in_valid[p]),
            .wr_data (in_word[p*PKT_W +: PKT_W]),
            .rd_en   (rd_en[p]),
            .rd_data (head[p]),
            .empty   (fifo_empty[p]),
            .stall   (in_stall[p])
        );
    end

    assign out_word = head[cur];
    assign out_port = cur;
    assign head_eof = out_word[EOF_BIT];

    grant_ctrl #(
        .N     (NUM_PORTS),
        .PW    (PORT_W),
        .CHUNK (CHUNK_WORDS)
    ) u_grant (
        .clk       (clk),
        .rst       (rst),
        .nonempty  (~fifo_empty),
        .head_eof  (head_eof),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .fire      (fire),
        .cur       (cur)
    );
endmodule

// File: rtl/pim_checker.sv
module pim_checker
    import pim_pkg::*;
#(
    parameter int NUM_PORTS   = PIM_PORTS,
    parameter int CHUNK_WORDS = PIM_CHUNK_WORDS
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         out_valid,
    input logic                         out_ready,
    input logic [PKT_W-1:0]             out_word,
    input logic [$clog2(NUM_PORTS)-1:0] out_port,
    input logic [NUM_PORTS-1:0]         fifo_empty
);
    localparam int PW = $clog2(NUM_PORTS);
    localparam int RW = $clog2(CHUNK_WORDS + 1);

    logic          pop;
    logic [RW-1:0] run_q;
    logic [PW-1:0] prev_q;

    assign pop = out_valid && out_ready;

    // independent count of words accepted in the running grant
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            prev_q <= '0;
        end else if (pop) begin
            prev_q <= out_port;
            run_q  <= (out_word[EOF_BIT] || run_q == RW'(CHUNK_WORDS - 1)) ? '0 : run_q + 1'b1;
        end
    end

    // R8
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_port));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        &fifo_empty |-> !out_valid);

    // R4
    tag_source_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !fifo_empty[out_port]);

    // R7
    chunk_switch_chk: assert property (@(posedge clk) disable iff (rst)
        pop && run_q != '0 |-> out_port == prev_q);
endmodule

bind pkt_ilv_mux pim_checker #(
    .NUM_PORTS   (NUM_PORTS),
    .CHUNK_WORDS (CHUNK_WORDS)
) u_pim_checker (
    .clk        (clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_word   (out_word),
    .out_port   (out_port),
    .fifo_empty (fifo_empty)
);

// File: tb/pkt_ilv_mux_bench.sv
`timescale 1ns/1ps
module pkt_ilv_mux_bench;
    import pim_pkg::*;

    localparam int NP = PIM_PORTS;
    localparam int W  = PKT_W;
    localparam int QD = 32;
    localparam int CH = PIM_CHUNK_WORDS;
    localparam int STALL_AT = PIM_DEPTH - PIM_STALL_FREE;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NP-1:0]         in_valid = '0;
    logic [NP*W-1:0]       in_word = '0;
    logic [NP-1:0]         in_stall;
    logic                  out_valid;
    logic                  out_ready = 1'b0;
    logic [W-1:0]          out_word;
    logic [$clog2(NP)-1:0] out_port;

    always #4 clk = ~clk;

    pkt_ilv_mux u_pkt_ilv_mux (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_stall  (in_stall),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word),
        .out_port  (out_port)
    );

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] qmem [NP][QD];
    int qwr [NP];
    int qrd [NP];
    int pkt_left [NP];
    int pkt_len  [NP];
    int serial = 0;

    int run_cnt  = 0;
    int run_port = -1;
    bit hold_pend = 1'b0;
    logic [W-1:0] hold_word;
    int hold_port;

    bit dmode = 1'b0;
    int dx_port [256];
    logic [W-1:0] dx_word [256];
    int dx_n = 0;
    int dx_i = 0;

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic logic [W-1:0] make_word(input int p, input bit sof, input bit eof, input int ser);
        pkt_word_t w;
        w.sof  = sof;
        w.eof  = eof;
        w.be   = BE_W'($urandom);
        w.data = {8'(p), 24'(ser), 32'($urandom), 32'($urandom), 32'($urandom)};
        return w;
    endfunction

    task automatic pop_word();
        int p;
        pkt_word_t w;
        p = int'(out_port);
        w = pkt_word_t'(out_word);
        chk(qrd[p] < qwr[p], $sformatf("R8 extra word on port %0d: act pops=%0d exp max=%0d", p, qrd[p] + 1, qwr[p]));
        if (qrd[p] < qwr[p]) begin
            chk(out_word == qmem[p][qrd[p] % QD],
                $sformatf("R1 R2 port %0d word: act=%h exp=%h", p, out_word, qmem[p][qrd[p] % QD]));
            qrd[p]++;
        end
        chk(int'(w.data[DATA_W-1 -: 8]) == p,
            $sformatf("R4 tag: act=%0d exp=%0d", p, int'(w.data[DATA_W-1 -: 8])));
        if (run_cnt != 0)
            chk(p == run_port, $sformatf("R7 switch inside grant: act port=%0d exp port=%0d", p, run_port));
        run_port = p;
        run_cnt  = (w.eof || run_cnt == CH - 1) ? 0 : run_cnt + 1;
        if (dmode) begin
            if (dx_i < dx_n)
                chk(p == dx_port[dx_i] && out_word == dx_word[dx_i],
                    $sformatf("R5 R6 R7 sequence idx %0d: act port=%0d exp port=%0d", dx_i, p, dx_port[dx_i]));
            else
                chk(1'b0, $sformatf("R8 extra word idx %0d: act port=%0d exp none", dx_i, p));
            dx_i++;
        end
    endtask

    // called at a falling edge with inputs already set; ends at the next falling edge
    task automatic step();
        #1;
        for (int p = 0; p < NP; p++)
            chk(in_stall[p] == ((qwr[p] - qrd[p]) >= STALL_AT),
                $sformatf("R3 port %0d stall: act=%0b exp=%0b (fill %0d)", p, in_stall[p],
                          ((qwr[p] - qrd[p]) >= STALL_AT), qwr[p] - qrd[p]));
        if (hold_pend)
            chk(out_valid && out_word == hold_word && int'(out_port) == hold_port,
                $sformatf("R8 held word: act valid=%0b port=%0d exp valid=1 port=%0d", out_valid, out_port, hold_port));
        hold_pend = out_valid && !out_ready;
        hold_word = out_word;
        hold_port = int'(out_port);
        if (out_valid && out_ready) pop_word();
        for (int p = 0; p < NP; p++) begin
            if (in_valid[p]) begin
                qmem[p][qwr[p] % QD] = in_word[p*W +: W];
                qwr[p]++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = '0;
    endtask

    task automatic rand_writes(input bit allow_new);
        for (int p = 0; p < NP; p++) begin
            if (!in_stall[p] && ($urandom % 4) != 0 && (pkt_left[p] > 0 || allow_new)) begin
                if (pkt_left[p] == 0) begin
                    pkt_len[p]  = 1 + int'($urandom % 20);
                    pkt_left[p] = pkt_len[p];
                end
                in_word[p*W +: W] = make_word(p, pkt_left[p] == pkt_len[p], pkt_left[p] == 1, serial);
                serial++;
                in_valid[p] = 1'b1;
                pkt_left[p]--;
            end
        end
    endtask

    // reference drain order of everything queued, no timing involved
    task automatic build_expected();
        int rdl [NP];
        int cur, p, n;
        bit hit;
        pkt_word_t w;
        for (int q = 0; q < NP; q++) rdl[q] = qrd[q];
        cur  = NP - 1;
        dx_n = 0;
        dx_i = 0;
        while (1) begin
            hit = 1'b0;
            p   = 0;
            for (int off = NP; off >= 1; off--) begin
                if (rdl[(cur + off) % NP] < qwr[(cur + off) % NP]) begin
                    hit = 1'b1;
                    p   = (cur + off) % NP;
                end
            end
            if (!hit) break;
            n = 0;
            while (rdl[p] < qwr[p]) begin
                w = pkt_word_t'(qmem[p][rdl[p] % QD]);
                dx_port[dx_n] = p;
                dx_word[dx_n] = w;
                dx_n++;
                rdl[p]++;
                n++;
                if (w.eof || n == CH) break;
            end
            cur = p;
        end
    endtask

    function automatic bit all_done();
        for (int p = 0; p < NP; p++)
            if (pkt_left[p] != 0 || qrd[p] != qwr[p]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int remaining();
        int r = 0;
        for (int p = 0; p < NP; p++) r += (qwr[p] - qrd[p]) + pkt_left[p];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        int len1 [NP];
        int len2 [NP];
        int guard;
        int tot, j;
        void'($urandom(32'd4242));
        for (int p = 0; p < NP; p++) begin
            qwr[p] = 0; qrd[p] = 0; pkt_left[p] = 0; pkt_len[p] = 0;
        end
        len1 = '{10, 0, 14, 3, 0, 0, 8, 1};
        len2 = '{0, 0, 0, 0, 0, 0, 2, 0};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!out_valid, $sformatf("R9 reset valid: act=%0b exp=0", out_valid));
        chk(in_stall == '0, $sformatf("R3 reset stall: act=%b exp=0", in_stall));
        @(negedge clk);

        // directed preload with downstream stalled: chunk split, exact-boundary eof, single-word packet
        out_ready = 1'b0;
        for (int i = 0; i < 14; i++) begin
            for (int p = 0; p < NP; p++) begin
                tot = len1[p] + len2[p];
                if (i < tot) begin
                    if (i < len1[p])
                        in_word[p*W +: W] = make_word(p, i == 0, i == len1[p] - 1, serial);
                    else begin
                        j = i - len1[p];
                        in_word[p*W +: W] = make_word(p, j == 0, j == len2[p] - 1, serial);
                    end
                    serial++;
                    in_valid[p] = 1'b1;
                end
            end
            step();
            if (i == 12) chk(!in_stall[2], $sformatf("R3 13 words: act=%0b exp=0", in_stall[2]));
            if (i == 13) chk(in_stall[2], $sformatf("R3 14 words: act=%0b exp=1", in_stall[2]));
        end
        chk(out_valid && out_port == 0,
            $sformatf("R5 first grant after reset: act valid=%0b port=%0d exp valid=1 port=0", out_valid, out_port));

        build_expected();
        dmode = 1'b1;
        guard = 0;
        while (dx_i < dx_n && guard < 600) begin
            out_ready = ($urandom % 2) != 0;
            step();
            guard++;
        end
        out_ready = 1'b0;
        dmode = 1'b0;
        chk(dx_i == dx_n, $sformatf("R8 directed words out: act=%0d exp=%0d", dx_i, dx_n));
        repeat (3) step();
        chk(!out_valid, $sformatf("R9 idle after drain: act=%0b exp=0", out_valid));

        // random traffic with random downstream backpressure
        for (int c = 0; c < 4000; c++) begin
            rand_writes(1'b1);
            out_ready = ($urandom % 3) != 0;
            step();
        end
        guard = 0;
        while (!all_done() && guard < 4000) begin
            rand_writes(1'b0);
            out_ready = 1'b1;
            step();
            guard++;
        end
        chk(all_done(), $sformatf("R8 all random words delivered: act left=%0d exp=0", remaining()));
        out_ready = 1'b1;
        repeat (3) step();
        chk(!out_valid, $sformatf("R9 idle after random: act=%0b exp=0", out_valid));

        summary();
        $finish;
    end
endmodule